// File: doc/BRIEF.md
# Guarded Four-Channel Tap Register Controller

This block keeps the tap settings of four 256-position potentiometers. Each channel has two registers. The first is a live wiper code, which drives the analogue switch network. The second is a retained data code, which stands in for non-volatile storage. A serial front end decodes each transaction and hands this block one strobe per write request. The strobe carries the target register kind, the channel and the 8-bit code.

Live wiper writes take effect on the next clock. Retained-code writes are only noted as pending while the transaction runs. They are committed when chip select is released, provided the front end reports that the transaction ended on a whole byte and the write-protect input is still high.

A commit starts an internal write cycle. The cycle lasts a parameterised number of clocks, and a busy flag is raised for its whole length. Once the cycle has started, write protect can no longer stop it. The block also reports a standby state, which means chip select is released and no write cycle is running.

Top module: `wiper_guard`

## Requirements
- R1: After reset, all four wiper codes and all four retained codes read 0x80, busy is low and standby follows chip select.
- R2: A request with reqIsData=0 while csN is low writes reqVal into wiper channel reqSel on the next clock. Other channels are unchanged. The write goes ahead even when wpN is low or busy is high.
- R3: A request with reqIsData=1 while csN is low does not change any retained code while chip select stays low.
- R4: A pending retained-code write starts a cycle when csN rises, provided byteAligned and wpN are high in that cycle. Busy is then high for exactly WRITE_CYCLES clocks starting on the next clock, and the retained code is updated on the same edge at which busy falls.
- R5: If byteAligned is low in the cycle csN rises, nothing is committed and busy stays low.
- R6: A retained-code request made while wpN is low is dropped. If wpN is low in any cycle between a request and the rise of csN, the pending write is cancelled.
- R7: Once busy is high, changes on wpN do not stop or alter the write cycle.
- R8: Retained-code requests that arrive while busy is high are dropped.
- R9: standby is high exactly when csN is high, busy is low and no cycle starts in that clock.
- R10: When several retained-code requests arrive in one chip-select window, only the last one is committed.
- R11: Requests that arrive while csN is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| wpN | input | 1 | Write protect, active low |
| byteAligned | input | 1 | Front end reports that the transaction holds whole bytes only |
| reqValid | input | 1 | One-cycle write request strobe |
| reqIsData | input | 1 | 1 = retained code, 0 = live wiper code |
| reqSel | input | 2 | Channel select |
| reqVal | input | 8 | Tap code |
| wiperCodes | output | 32 | Live wiper codes; channel n sits at bits [8n+7:8n] |
| dataCodes | output | 32 | Retained codes; channel n sits at bits [8n+7:8n] |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Chip select released and idle |

## Verification
The assertions assume that all inputs are synchronous to clk and change only between edges. They also assume that reqValid is a single-cycle strobe, so a request never coincides with the edge at which csN rises in a directed transaction.

The bench drives every input a short delay after the rising edge, so these assumptions hold. In the directed part, it always lowers chip select for a clock or more before the first request. In the random part, it mixes chip-select toggles, protect pulses and requests freely, and a behavioural model follows every input combination, including requests that fall on a chip-select edge.

// File: rtl/wg_pkg.sv
package wg_pkg;
  parameter int NUM_POTS   = 4;
  parameter int CODE_W     = 8;
  localparam int SEL_W     = $clog2(NUM_POTS);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));

  typedef struct packed {
    logic              wiperWe;
    logic [SEL_W-1:0]  wiperSel;
    logic [CODE_W-1:0] wiperVal;
    logic              dataWe;
    logic [SEL_W-1:0]  dataSel;
    logic [CODE_W-1:0] dataVal;
  } wg_strobe_t;
endpackage

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import wg_pkg::*;
#(
  parameter int WRITE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wpN,
  input  logic              byteAligned,
  input  logic              reqValid,
  input  logic              reqIsData,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [CODE_W-1:0] reqVal,
  output wg_strobe_t        strb,
  output logic              busy,
  output logic              standby
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic              csPrev;
  logic              pendValid;
  logic [SEL_W-1:0]  pendSel;
  logic [CODE_W-1:0] pendVal;
  logic [SEL_W-1:0]  wrSel;
  logic [CODE_W-1:0] wrVal;
  logic [CNT_W-1:0]  cnt;

  logic csRise, csFall, dataAccept, startNow;

  assign csRise     = csN && !csPrev;
  assign csFall     = !csN && csPrev;
  assign dataAccept = reqValid && reqIsData && !csN && wpN && !busy;
  assign startNow   = csRise && pendValid && byteAligned && wpN && !busy;

  // Pending write capture: protect low or chip-select rise always clears it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev    <= 1'b1;
      pendValid <= 1'b0;
      pendSel   <= '0;
      pendVal   <= '0;
    end else begin
      csPrev <= csN;
      if (csRise || !wpN) begin
        pendValid <= 1'b0;
      end else if (dataAccept) begin
        pendValid <= 1'b1;
        pendSel   <= reqSel;
        pendVal   <= reqVal;
      end else if (csFall) begin
        pendValid <= 1'b0;
      end
    end
  end

  // Timed internal write cycle; snapshot decouples it from protect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      wrSel <= '0;
      wrVal <= '0;
    end else if (startNow) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(WRITE_CYCLES - 1);
      wrSel <= pendSel;
      wrVal <= pendVal;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_comb begin
    strb.wiperWe  = reqValid && !reqIsData && !csN;
    strb.wiperSel = reqSel;
    strb.wiperVal = reqVal;
    strb.dataWe   = busy && (cnt == '0);
    strb.dataSel  = wrSel;
    strb.dataVal  = wrVal;
  end

  assign standby = csN && !busy && !startNow;

  // A cycle may only begin on released chip select with protect high
  assert_start_guard_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(csN) && $past(wpN) && $past(byteAligned)));
  assert_start_protect_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wpN));
  // Nothing may be pending while a cycle runs
  assert_busy_no_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !pendValid);
  // The end of a cycle always coincides with a retained write
  assert_end_commits_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.dataWe));
  assert_standby_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !standby);
endmodule

// File: rtl/wg_datapath.sv
module wg_datapath
  import wg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  wg_strobe_t                 strb,
  output logic [NUM_POTS*CODE_W-1:0] wiperCodes,
  output logic [NUM_POTS*CODE_W-1:0] dataCodes
);
  logic [CODE_W-1:0] wiperRegs [NUM_POTS];
  logic [CODE_W-1:0] dataRegs  [NUM_POTS];

  for (genvar ch = 0; ch < NUM_POTS; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wiperRegs[ch] <= MID_CODE;
        dataRegs[ch]  <= MID_CODE;
      end else begin
        if (strb.wiperWe && (strb.wiperSel == SEL_W'(ch))) wiperRegs[ch] <= strb.wiperVal;
        if (strb.dataWe && (strb.dataSel == SEL_W'(ch)))   dataRegs[ch]  <= strb.dataVal;
      end
    end
    assign wiperCodes[ch*CODE_W +: CODE_W] = wiperRegs[ch];
    assign dataCodes[ch*CODE_W +: CODE_W]  = dataRegs[ch];

    // Retained codes move only on a commit strobe
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.dataWe && (strb.dataSel == SEL_W'(ch))) |=> $stable(dataRegs[ch]));
    assert_wiper_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wiperWe && (strb.wiperSel == SEL_W'(ch))) |=> (wiperRegs[ch] == $past(strb.wiperVal)));
  end
endmodule

// File: rtl/wiper_guard.sv
module wiper_guard
  import wg_pkg::*;
#(
  parameter int WRITE_CYCLES = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       wpN,
  input  logic                       byteAligned,
  input  logic                       reqValid,
  input  logic                       reqIsData,
  input  logic [SEL_W-1:0]           reqSel,
  input  logic [CODE_W-1:0]          reqVal,
  output logic [NUM_POTS*CODE_W-1:0] wiperCodes,
  output logic [NUM_POTS*CODE_W-1:0] dataCodes,
  output logic                       busy,
  output logic                       standby
);
  wg_strobe_t strb;

  wg_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .byteAligned(byteAligned),
    .reqValid(reqValid), .reqIsData(reqIsData), .reqSel(reqSel), .reqVal(reqVal),
    .strb(strb), .busy(busy), .standby(standby)
  );

  wg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wiperCodes(wiperCodes), .dataCodes(dataCodes)
  );
endmodule

// File: tb/wiper_guard_bench.sv
`timescale 1ns/1ps
module wiper_guard_bench;
  localparam int WC = 6;
  logic clk = 0, rstN = 0, csN = 1, wpN = 1, byteAligned = 1;
  logic reqValid = 0, reqIsData = 0;
  logic [1:0] reqSel = 0;
  logic [7:0] reqVal = 0;
  logic [31:0] wiperCodes, dataCodes;
  logic busy, standby;
  int checks = 0, failures = 0, cycles = 0;

  wiper_guard #(.WRITE_CYCLES(WC)) u_wiper_guard (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .byteAligned(byteAligned),
    .reqValid(reqValid), .reqIsData(reqIsData), .reqSel(reqSel), .reqVal(reqVal),
    .wiperCodes(wiperCodes), .dataCodes(dataCodes), .busy(busy), .standby(standby));

  always #10 clk = ~clk;

  // Behavioural reference model
  int mWip[4], mDat[4];
  int mPend, mPendSel, mPendVal, mBusy, mCnt, mWs, mWv, mCsPrev;
  always @(posedge clk) begin
    bit rise, fall, acc, start;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mWip[i] = 128; mDat[i] = 128; end
      mPend = 0; mBusy = 0; mCnt = 0; mCsPrev = 1; mPendSel = 0; mPendVal = 0; mWs = 0; mWv = 0;
    end else begin
      rise = csN && !mCsPrev;
      fall = !csN && mCsPrev;
      acc = reqValid && reqIsData && !csN && wpN && !mBusy;
      start = rise && mPend != 0 && byteAligned && wpN && !mBusy;
      if (reqValid && !reqIsData && !csN) mWip[reqSel] = reqVal;
      if (start) begin
        mBusy = 1; mCnt = WC - 1; mWs = mPendSel; mWv = mPendVal;
      end else if (mBusy != 0) begin
        if (mCnt == 0) begin mDat[mWs] = mWv; mBusy = 0; end
        else mCnt = mCnt - 1;
      end
      if (rise || !wpN) mPend = 0;
      else if (acc) begin mPend = 1; mPendSel = reqSel; mPendVal = reqVal; end
      else if (fall) mPend = 0;
      mCsPrev = csN;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the rising edge
  always @(negedge clk) if (rstN) begin
    bit startE;
    startE = csN && !mCsPrev && mPend != 0 && byteAligned && wpN && mBusy == 0;
    for (int c = 0; c < 4; c++) begin
      chk(int'(wiperCodes[c*8 +: 8]), mWip[c], "R2 wiper code vs model");
      chk(int'(dataCodes[c*8 +: 8]), mDat[c], "R4 retained code vs model");
    end
    chk(int'(busy), mBusy, "R4 busy vs model");
    chk(int'(standby), int'(csN && mBusy == 0 && !startE), "R9 standby vs model");
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask
  task automatic req(input bit isData, input int sel, input int val);
    reqValid = 1; reqIsData = isData; reqSel = 2'(sel); reqVal = 8'(val);
    tick(1);
    reqValid = 0;
  endtask
  function automatic int dat(input int c); return int'(dataCodes[c*8 +: 8]); endfunction
  function automatic int wip(input int c); return int'(wiperCodes[c*8 +: 8]); endfunction

  initial begin
    tick(3); rstN = 1; @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      chk(wip(c), 8'h80, "R1 reset wiper");
      chk(dat(c), 8'h80, "R1 reset retained");
    end
    chk(busy, 0, "R1 reset busy");
    chk(standby, 1, "R1 reset standby");
    tick(1);
    // R11: requests with chip select high do nothing
    req(0, 1, 8'hEE); req(1, 1, 8'hEF); tick(WC + 2); @(negedge clk);
    chk(wip(1), 8'h80, "R11 wiper untouched"); chk(dat(1), 8'h80, "R11 retained untouched");
    tick(1);
    // R2: live writes, also under protect
    csN = 0; tick(1); req(0, 2, 8'h11); @(negedge clk);
    chk(wip(2), 8'h11, "R2 wiper write");
    tick(1); wpN = 0; req(0, 0, 8'h22); @(negedge clk);
    chk(wip(0), 8'h22, "R2 wiper write under protect");
    tick(1); wpN = 1; tick(1);
    // R3/R4/R7/R9: commit
    req(1, 1, 8'h5A); tick(2); @(negedge clk);
    chk(dat(1), 8'h80, "R3 retained held while selected");
    tick(1); csN = 1; tick(1); @(negedge clk);
    chk(busy, 1, "R4 busy after rise"); chk(standby, 0, "R9 no standby while busy");
    tick(1); wpN = 0; tick(1);
    csN = 0; tick(1); req(1, 3, 8'h77); req(0, 3, 8'h66);
    wpN = 1;
    tick(WC); @(negedge clk);
    chk(dat(1), 8'h5A, "R7 commit completed despite protect");
    chk(busy, 0, "R4 busy ended");
    chk(wip(3), 8'h66, "R2 wiper write while busy");
    tick(1); csN = 1; tick(WC + 2); @(negedge clk);
    chk(dat(3), 8'h80, "R8 request while busy dropped");
    chk(standby, 1, "R9 standby when idle");
    tick(1);
    // R5: misaligned transaction
    csN = 0; tick(1); req(1, 2, 8'h99); byteAligned = 0; tick(1); csN = 1; tick(1);
    @(negedge clk); chk(busy, 0, "R5 no cycle on partial byte");
    byteAligned = 1; tick(WC + 2); @(negedge clk); chk(dat(2), 8'h80, "R5 nothing committed");
    tick(1);
    // R6: protect at request, and protect pulse before release
    csN = 0; wpN = 0; tick(1); req(1, 0, 8'h31); wpN = 1; tick(1); csN = 1; tick(WC + 2);
    @(negedge clk); chk(dat(0), 8'h80, "R6 protected request dropped");
    tick(1); csN = 0; tick(1); req(1, 0, 8'h32); wpN = 0; tick(1); wpN = 1; tick(1); csN = 1; tick(WC + 2);
    @(negedge clk); chk(dat(0), 8'h80, "R6 protect pulse cancels");
    tick(1);
    // R10: last request wins
    csN = 0; tick(1); req(1, 2, 8'h33); req(1, 0, 8'h44); tick(1); csN = 1; tick(WC + 2);
    @(negedge clk); chk(dat(0), 8'h44, "R10 last request committed");
    chk(dat(2), 8'h80, "R10 earlier request discarded");
    tick(1);
    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      csN = ($urandom % 8) == 0 ? ~csN : csN;
      wpN = ($urandom % 16) != 0;
      byteAligned = ($urandom % 6) != 0;
      reqValid = ($urandom % 3) == 0;
      reqIsData = $urandom % 2;
      reqSel = 2'($urandom); reqVal = 8'($urandom);
      tick(1);
    end
    reqValid = 0; csN = 1; tick(WC + 4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule